// File: doc/BRIEF.md
# Synchronous Delay-Line Phase Filter with Dual-Modulus Divider

This block produces a divided clock and a delayed copy of it. It also produces two phase-error signals that compare a reference against both of them. A modulus-2/3 counter runs on the fast oscillator clock. At the end of every output period it takes a one-bit request that sets the length of the next period. Its output passes down a shift chain of flip-flops clocked by the same oscillator clock. A registered tap select chooses how many stages the delayed copy has passed through.

The chain and the divider share one clock. A period stretched by a swallowed cycle therefore moves down the chain with its edges unchanged. The delayed copy is the divider output shifted by a whole number of clock periods, with no resampling. Two XOR detectors form the reference XOR the present divider phase and the reference XOR the past divider phase. They are presented as two separate signals of equal weight, for analog summing outside the block. The nominal setting is 24 stages (tap code 23). The chain holds up to 32 stages by default.

Top module: `phase_delay_filter`

## Requirements
- R1: A synchronous reset clears the divider counter, the latched modulus, the tap register and every chain stage. In the cycle after reset, div_out and div_dly both read 0.
- R2: With the modulus request at 0 (modulus 2), div_out repeats a period of two clocks: one clock low, then one clock high.
- R3: With the modulus request at 1 (modulus 3), div_out repeats a period of three clocks: one clock low, then two clocks high. The added clock is the swallowed cycle.
- R4: mod3_req is sampled only on the clock edge that ends the last clock of a period, and that value sets the length of the next period. At any other edge its value has no effect on div_out. After reset the first period uses modulus 2.
- R5: For a tap code t (0 to STAGES-1), div_dly equals div_out delayed by exactly t+1 clock periods. Stages not yet filled since reset read 0.
- R6: tap_sel is registered. A new code sets the delay seen on div_dly starting with the first clock edge after it is applied.
- R7: pd_now equals ref_in XOR div_out, with no clock delay.
- R8: pd_past equals ref_in XOR div_dly, with no clock delay.
- R9: Through any mix of modulus-2 and modulus-3 periods, div_dly keeps the exact sequence of high and low lengths of div_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast oscillator clock; clocks the divider and every chain stage |
| rst | input | 1 | Synchronous reset, active high |
| mod3_req | input | 1 | Modulus request: 0 selects divide-by-2, 1 selects divide-by-3 |
| tap_sel | input | SEL_W | Tap code t, giving a delay of t+1 stages |
| ref_in | input | 1 | Reference phase input |
| div_out | output | 1 | Divider output |
| div_dly | output | 1 | Divider output delayed by the selected number of stages |
| pd_now | output | 1 | Reference XOR present divider output |
| pd_past | output | 1 | Reference XOR delayed divider output |

## Verification
A period wrap that latches a new modulus can fall on the same clock edge as a tap-select change. The delay must then follow the new code while the divider starts a period of the new length. The bench provokes this by changing the tap code every few cycles while a pseudo-random modulus request toggles. Every sampled div_out is compared against a period model built from the requirements. Every div_dly is compared against the logged history of div_out, shifted by the tap code in force at the preceding edge.

// File: rtl/phase_delay_filter.sv
module phase_delay_filter #(
  parameter int STAGES_LOG2 = 5,
  localparam int STAGES = 1 << STAGES_LOG2,
  localparam int SEL_W = STAGES_LOG2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mod3_req,
  input  logic [SEL_W-1:0] tap_sel,
  input  logic             ref_in,
  output logic             div_out,
  output logic             div_dly,
  output logic             pd_now,
  output logic             pd_past
);

  logic [1:0]        cnt;
  logic              mod3_q;
  logic [STAGES-1:0] line;
  logic [SEL_W-1:0]  sel_q;
  logic              wrap;

  assign wrap = mod3_q ? (cnt == 2'd2) : (cnt == 2'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      mod3_q <= 1'b0;
    end else if (wrap) begin
      cnt    <= '0;
      mod3_q <= mod3_req;
    end else begin
      cnt    <= cnt + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line  <= '0;
      sel_q <= '0;
    end else begin
      line  <= {line[STAGES-2:0], div_out};
      sel_q <= tap_sel;
    end
  end

  assign div_out = (cnt != 2'd0);
  assign div_dly = line[sel_q];
  assign pd_now  = ref_in ^ div_out;
  assign pd_past = ref_in ^ div_dly;

endmodule

// File: rtl/phase_delay_filter_chk.sv
module phase_delay_filter_chk #(
  parameter int SEL_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic [SEL_W-1:0] tap_sel,
  input logic             ref_in,
  input logic             div_out,
  input logic             div_dly,
  input logic             pd_past
);

  logic [1:0] age;

  always_ff @(posedge clk) begin
    if (rst) age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!div_out && !div_dly));

  a_r2_low_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (age != 2'd0 && !div_out) |=> div_out);

  a_r3_high_at_most_two: assert property (@(posedge clk) disable iff (rst)
    (age != 2'd0 && div_out && $past(div_out)) |=> !div_out);

  a_r5_first_stage: assert property (@(posedge clk) disable iff (rst)
    (age != 2'd0 && $past(tap_sel) == '0) |-> (div_dly == $past(div_out)));

  a_r8_past_detector: assert property (@(posedge clk) disable iff (rst)
    (age != 2'd0 && $past(tap_sel) == '0) |-> (pd_past == (ref_in ^ $past(div_out))));

endmodule

bind phase_delay_filter phase_delay_filter_chk #(.SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst(rst), .tap_sel(tap_sel), .ref_in(ref_in),
  .div_out(div_out), .div_dly(div_dly), .pd_past(pd_past)
);

// File: tb/phase_delay_filter_bench.sv
module phase_delay_filter_bench;
  localparam int SEL_W = 5;
  localparam int HIST = 8192;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mod3_req = 1'b0;
  logic [SEL_W-1:0] tap_sel = '0;
  logic ref_in = 1'b0;
  logic div_out, div_dly, pd_now, pd_past;

  always #2.5 clk = ~clk;

  phase_delay_filter u_phase_delay_filter (
    .clk(clk), .rst(rst), .mod3_req(mod3_req), .tap_sel(tap_sel),
    .ref_in(ref_in), .div_out(div_out), .div_dly(div_dly),
    .pd_now(pd_now), .pd_past(pd_past)
  );

  int total = 0;
  int bad = 0;
  int n = 0;
  int rst_idx = 1 << 30;
  logic hist [HIST];
  int m_cnt = 0;
  logic m_mod3 = 1'b0;
  int cur_sel = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit done = 0;

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s cycle %0d: actual=%b expected=%b", tag, n, act, exp);
    end
  endtask

  function automatic logic rnd();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  task automatic step(input logic r, input logic req, input int sel,
                      input logic refv, input string tag);
    logic e_dly;
    @(negedge clk);
    if (n >= rst_idx) begin
      chk({tag, " div_out"}, div_out, logic'(m_cnt != 0));
      if (n - (cur_sel + 1) >= rst_idx) e_dly = hist[(n - (cur_sel + 1)) % HIST];
      else e_dly = 1'b0;
      chk({tag, " div_dly"}, div_dly, e_dly);
    end
    hist[n % HIST] = div_out;
    rst = r;
    mod3_req = req;
    tap_sel = SEL_W'(sel);
    ref_in = refv;
    #1;
    if (n >= rst_idx) begin
      chk("R7 pd_now", pd_now, refv ^ div_out);
      chk("R8 pd_past", pd_past, refv ^ div_dly);
    end
    if (r) begin
      m_cnt = 0;
      m_mod3 = 1'b0;
      rst_idx = n + 1;
    end else if (m_cnt == (m_mod3 ? 2 : 1)) begin
      m_cnt = 0;
      m_mod3 = req;
    end else begin
      m_cnt++;
    end
    cur_sel = sel;
    n++;
  endtask

  task automatic t_reset();
    step(1, 1, 23, 0, "R1");
    step(1, 1, 23, 1, "R1");
    step(0, 0, 23, 0, "R1");
    chk("R1 div_out after reset", div_out, 1'b0);
    chk("R1 div_dly after reset", div_dly, 1'b0);
  endtask

  task automatic t_mod2();
    for (int i = 0; i < 60; i++) step(0, 0, 23, rnd(), "R2");
  endtask

  task automatic t_mod3();
    for (int i = 0; i < 60; i++) step(0, 1, 23, rnd(), "R3");
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 120; i++) step(0, logic'(i % 2), 23, rnd(), "R4");
    step(1, 1, 23, 0, "R4");
    for (int i = 0; i < 60; i++) step(0, rnd(), 23, rnd(), "R4");
  endtask

  task automatic t_taps();
    for (int s = 0; s < 32; s++)
      for (int i = 0; i < 45; i++) step(0, rnd(), s, rnd(), "R5");
  endtask

  task automatic t_tapchange();
    for (int i = 0; i < 300; i++) begin
      logic q = rnd();
      step(0, q, (i / 3) * 7 % 32, rnd(), "R6");
    end
  endtask

  task automatic t_mixed();
    logic q = 1'b0;
    for (int i = 0; i < 400; i++) begin
      if (i % 5 == 0) q = rnd();
      step(0, q, 23, rnd(), "R9");
    end
  endtask

  initial begin
    #500000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_mod2();
    t_mod3();
    t_wrap();
    t_taps();
    t_tapchange();
    t_mixed();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule